// File: doc/BRIEF.md
# Serial LED Channel Data Path

This block is the digital control path of a sixteen-channel constant-current LED sink driver. Serial bits enter on a single input and move through a sixteen-bit shift register on every rising clock edge; the register's top bit leaves on a serial output, so several drivers can be chained on one data line. A latch strobe copies the register into one of two places. In normal mode it goes to the sixteen-bit channel latch that decides which LEDs are lit. In special mode it goes to an eight-bit configuration byte that sets the analog current gain.

Each channel sinks current only when its latch bit is set and the active-low output enable is held low. In special mode the same shift register doubles as the readout path for per-channel fault status. A run of low samples on the output enable switches the register's input from the serial pin to the parallel status word. When the enable returns high, the captured status shifts out, bit 15 first.

The mode sequencer, the analog regulation and the fault sensing lie outside this block. They reach it as a mode level, a latch-inhibit level, a status-clear pulse and sixteen synchronous fault flags.

Top module: `led_serial_path`

## Requirements
- R1: On every rising clock edge where no status capture happens, the shift register moves up one place, `ser_in` enters bit 0, and `ser_out` always shows bit 15.
- R2: In normal mode (`special_mode` = 0), a strobe sampled high at a rising edge writes the post-shift register value into the channel latch. The latch holds its value at every edge where the strobe is low.
- R3: In special mode, a sampled strobe writes bits 7..0 of the post-shift register into `cfg_byte` and leaves the channel latch unchanged. Bits 15..8 have no effect on `cfg_byte`.
- R4: After reset, `cfg_byte` is 8'hFF and the channel latch is all zeros. `cfg_byte` keeps its value until a special-mode strobe writes it.
- R5: `chan_on[i]` is 1 only when channel latch bit i is 1 and `oe_n` is 0. With `oe_n` high, all channels are off.
- R6: In special mode, the first two consecutive low samples of `oe_n` still shift in from `ser_in`. The third and every later consecutive low sample load the parallel status word into the register instead.
- R7: After `oe_n` returns high, the register takes its input from `ser_in` again. The captured status then appears on `ser_out` bit 15 first, one bit per edge.
- R8: Bit i of the status word is 1 only when channel i has no stored fault and its channel latch bit is 1. Otherwise it is 0.
- R9: A fault flag sampled high clears its stored status bit, and the bit stays cleared until a `status_clear` pulse. The pulse, which wins over a fault in the same cycle, sets all bits back to healthy. Reset also sets all bits healthy.
- R10: While `latch_inhibit` is high, the strobe writes neither the channel latch nor `cfg_byte`.
- R11: In normal mode, `oe_n` held low for any number of cycles never loads the status word; the register keeps shifting `ser_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| latch_strobe | input | 1 | Latch strobe, sampled on the rising edge |
| oe_n | input | 1 | Active-low output enable |
| special_mode | input | 1 | Mode from the sequencer: 1 = special, 0 = normal |
| latch_inhibit | input | 1 | Blocks the strobe during mode switching |
| status_clear | input | 1 | Single-cycle pulse that restores every status bit to healthy |
| fault_flags | input | 16 | Synchronous per-channel fault indications, 1 = fault |
| ser_out | output | 1 | Serial output, register bit 15 |
| chan_on | output | 16 | Per-channel sink enable |
| cfg_byte | output | 8 | Configuration byte (bit 0 multiplier, bit 1 band select, bits 7..2 gain) |

## Verification
On every cycle the assertions check several properties. Bit 0 of the register follows the serial input whenever no capture happens. A capture is always preceded by two low special-mode enable samples. Neither latch moves without an uninhibited strobe, and the channel latch never moves in special mode. Status bits never recover without a clear. All channels go dark under a high enable. The bench scenarios are needed for the rest: the exact latched and configured values, the status readout order after the enable rises, the combination of stored faults with unlit channels in the status word, and the absence of capture in normal mode. The bench compares against an independent model under both directed sequences and seeded random traffic.

// File: rtl/led_serial_path_pkg.sv
// Package: shared widths and vector types for the serial LED channel data path.
// Assumes a single clock domain; every type below is sized from these constants.
package led_serial_path_pkg;
    localparam int unsigned NUM_CHAN   = 16;
    localparam int unsigned CFG_BITS   = 8;
    localparam int unsigned LOW_RUN    = 2;
    localparam logic [CFG_BITS-1:0] CFG_RESET = '1;

    typedef logic [NUM_CHAN-1:0] chan_vec_t;
    typedef logic [CFG_BITS-1:0] cfg_vec_t;
endpackage

// File: rtl/lsp_shift_reg.sv
// Module: shift register with a switchable input source.
// Shifts ser_in in at bit 0 on every edge. In special mode, once LOW_RUN
// consecutive low samples of oe_n have been seen, each further low sample
// loads the parallel status word instead. Assumes LOW_RUN >= 2 and NCH >= 2.
module lsp_shift_reg #(
    parameter int unsigned NCH     = 16,
    parameter int unsigned LOW_RUN = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_in,
    input  logic           special_mode,
    input  logic           oe_n,
    input  logic [NCH-1:0] status_word,
    output logic [NCH-1:0] sr_q,
    output logic [NCH-1:0] sr_next,
    output logic           capture
);
    localparam int unsigned CW = $clog2(LOW_RUN + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(LOW_RUN);

    logic [CW-1:0] low_cnt_q;

    // Pick the register's next value: the parallel status word or a one-place shift.
    always_comb begin
        capture = special_mode && !oe_n && (low_cnt_q == RUN_MAX);
        sr_next = capture ? status_word : {sr_q[NCH-2:0], ser_in};
    end

    // Count consecutive special-mode low samples of oe_n, saturating at LOW_RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!special_mode || oe_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != RUN_MAX) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Register the selected next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_next;
        end
    end

    // R1: with no capture, bit 0 takes the serial input sampled at that edge
    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> sr_q[0] == $past(ser_in));

    // R6: a capture needs the two preceding edges to have seen special mode with oe_n low
    assert_capture_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> ($past(special_mode) && !$past(oe_n)
                     && $past(special_mode, 2) && !$past(oe_n, 2)));

    // R11: no capture outside special mode
    assert_no_capture_normal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !special_mode |-> !capture);
endmodule

// File: rtl/lsp_latches.sv
// Module: channel latch and configuration byte.
// A strobe sampled high on a rising edge, when not inhibited, writes the
// post-shift register value into the channel latch (normal mode) or its low
// CFG_W bits into the configuration byte (special mode).
module lsp_latches #(
    parameter int unsigned NCH   = 16,
    parameter int unsigned CFG_W = 8,
    parameter logic [CFG_W-1:0] CFG_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_strobe,
    input  logic             latch_inhibit,
    input  logic             special_mode,
    input  logic [NCH-1:0]   sr_next,
    output logic [NCH-1:0]   lat_q,
    output logic [CFG_W-1:0] cfg_q
);
    logic wr_en;
    logic wr_lat;
    logic wr_cfg;

    // Decode which latch, if any, takes this edge's strobe.
    always_comb begin
        wr_en  = latch_strobe && !latch_inhibit;
        wr_lat = wr_en && !special_mode;
        wr_cfg = wr_en && special_mode;
    end

    // Channel latch update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (wr_lat) begin
            lat_q <= sr_next;
        end
    end

    // Configuration byte update; upper register bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_INIT;
        end else if (wr_cfg) begin
            cfg_q <= sr_next[CFG_W-1:0];
        end
    end

    // R2: without a strobe the channel latch holds
    assert_lat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_strobe |=> $stable(lat_q));

    // R3: a special-mode edge never changes the channel latch
    assert_special_no_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        special_mode |=> $stable(lat_q));

    // R4: the configuration byte holds unless a special-mode strobe arrives
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_strobe && special_mode) |=> $stable(cfg_q));

    // R10: an inhibited strobe touches neither latch
    assert_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        latch_inhibit |=> ($stable(lat_q) && $stable(cfg_q)));
endmodule

// File: rtl/lsp_fault_status.sv
// Module: sticky per-channel health bits.
// A bit starts healthy (1), is cleared by a sampled fault flag and stays
// cleared until status_clear, which has priority over faults in the same cycle.
module lsp_fault_status #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fault_flags,
    input  logic           status_clear,
    output logic [NCH-1:0] healthy_q
);
    // Update the health bits, one per channel.
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            always_ff @(posedge clk) begin
                if (!rst_n || status_clear) begin
                    healthy_q[i] <= 1'b1;
                end else if (fault_flags[i]) begin
                    healthy_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    // R9: a clear pulse leaves every bit healthy
    assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_clear |=> (&healthy_q));

    // R9: without a clear no bit returns to healthy
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clear |=> ((healthy_q & ~$past(healthy_q)) == '0));
endmodule

// File: rtl/led_serial_path.sv
// Module: top of the serial LED channel data path.
// Joins the shift register, the two latches and the health bits, forms the
// status word (healthy and lit) and gates the channel enables with oe_n.
// Assumes all inputs are synchronous to clk.
module led_serial_path
    import led_serial_path_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                latch_strobe,
    input  logic                oe_n,
    input  logic                special_mode,
    input  logic                latch_inhibit,
    input  logic                status_clear,
    input  logic [NUM_CHAN-1:0] fault_flags,
    output logic                ser_out,
    output logic [NUM_CHAN-1:0] chan_on,
    output logic [CFG_BITS-1:0] cfg_byte
);
    chan_vec_t sr_q;
    chan_vec_t sr_next;
    chan_vec_t lat_q;
    chan_vec_t healthy_q;
    chan_vec_t status_word;
    cfg_vec_t  cfg_q;
    logic      capture;

    // Status word: a channel reads healthy only if it has no fault and is lit.
    always_comb status_word = healthy_q & lat_q;

    lsp_shift_reg #(.NCH(NUM_CHAN), .LOW_RUN(LOW_RUN)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_in       (ser_in),
        .special_mode (special_mode),
        .oe_n         (oe_n),
        .status_word  (status_word),
        .sr_q         (sr_q),
        .sr_next      (sr_next),
        .capture      (capture)
    );

    lsp_latches #(.NCH(NUM_CHAN), .CFG_W(CFG_BITS), .CFG_INIT(CFG_RESET)) u_latches (
        .clk           (clk),
        .rst_n         (rst_n),
        .latch_strobe  (latch_strobe),
        .latch_inhibit (latch_inhibit),
        .special_mode  (special_mode),
        .sr_next       (sr_next),
        .lat_q         (lat_q),
        .cfg_q         (cfg_q)
    );

    lsp_fault_status #(.NCH(NUM_CHAN)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_flags  (fault_flags),
        .status_clear (status_clear),
        .healthy_q    (healthy_q)
    );

    // Drive the outputs: cascade bit, gated channel enables, configuration byte.
    always_comb begin
        ser_out  = sr_q[NUM_CHAN-1];
        chan_on  = lat_q & {NUM_CHAN{~oe_n}};
        cfg_byte = cfg_q;
    end

    // R5: a high enable blanks every channel
    assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (chan_on == '0));

    // R7: the top bit after a capture edge comes from the captured status word
    assert_readout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ser_out == $past(status_word[NUM_CHAN-1]));
endmodule

// File: tb/led_serial_path_bench.sv
// Bench: directed corner cases plus seeded random traffic, compared each
// cycle against a model built from the requirements.
module led_serial_path_bench;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, latch_strobe = 1'b0, oe_n = 1'b1;
    logic special_mode = 1'b0, latch_inhibit = 1'b0, status_clear = 1'b0;
    logic [N-1:0] fault_flags = '0;
    logic ser_out;
    logic [N-1:0] chan_on;
    logic [7:0] cfg_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [N-1:0] m_sr, m_lat, m_ok;
    logic [7:0]   m_cfg;
    int           m_low;

    always #2 clk = ~clk;

    led_serial_path u_led_serial_path (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_strobe(latch_strobe),
        .oe_n(oe_n), .special_mode(special_mode), .latch_inhibit(latch_inhibit),
        .status_clear(status_clear), .fault_flags(fault_flags),
        .ser_out(ser_out), .chan_on(chan_on), .cfg_byte(cfg_byte)
    );

    function automatic logic [N-1:0] status_of(logic [N-1:0] ok, logic [N-1:0] lat);
        return ok & lat;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(logic si, logic le, logic oe, logic sp, logic inh,
                        logic clr, logic [N-1:0] flt, string tag);
        logic [N-1:0] nxt;
        bit cap;
        ser_in = si; latch_strobe = le; oe_n = oe; special_mode = sp;
        latch_inhibit = inh; status_clear = clr; fault_flags = flt;
        @(posedge clk);
        cap = sp && !oe && (m_low >= 2);
        nxt = cap ? status_of(m_ok, m_lat) : {m_sr[N-2:0], si};
        if (le && !inh && !sp) m_lat = nxt;
        if (le && !inh && sp)  m_cfg = nxt[7:0];
        m_sr = nxt;
        m_ok = clr ? '1 : (m_ok & ~flt);
        m_low = (sp && !oe) ? ((m_low < 2) ? m_low + 1 : 2) : 0;
        @(negedge clk);
        check(ser_out == m_sr[N-1], {tag, " ser_out"}, 32'(ser_out), 32'(m_sr[N-1]));
        check(chan_on == (m_lat & {N{~oe}}), {tag, " chan_on"}, 32'(chan_on),
              32'(m_lat & {N{~oe}}));
        check(cfg_byte == m_cfg, {tag, " cfg_byte"}, 32'(cfg_byte), 32'(m_cfg));
    endtask

    task automatic shift_word(logic [N-1:0] w, logic sp, string tag);
        for (int i = N - 1; i >= 0; i--)
            step(w[i], (i == 0), 1'b1, sp, 1'b0, 1'b0, '0, tag);
    endtask

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] word;
        logic [N-1:0] rd;
        int seed_dummy;
        m_sr = '0; m_lat = '0; m_ok = '1; m_cfg = 8'hFF; m_low = 0;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset values
        check(cfg_byte == 8'hFF, "R4 reset cfg", 32'(cfg_byte), 32'hFF);
        check(chan_on == '0, "R4 reset chan_on", 32'(chan_on), 0);
        check(ser_out == 1'b0, "R1 reset ser_out", 32'(ser_out), 0);

        // R1/R2: normal load, then enable outputs
        shift_word(16'hA5C3, 1'b0, "R2");
        step(0, 0, 0, 0, 0, 0, '0, "R5");
        check(chan_on == 16'hA5C3, "R2 latched", 32'(chan_on), 32'hA5C3);
        step(1, 0, 1, 0, 0, 0, '0, "R5");
        check(chan_on == '0, "R5 blank", 32'(chan_on), 0);

        // R10: inhibited strobe
        for (int i = 0; i < N; i++) step(1, 1, 1, 0, 1, 0, '0, "R10");
        step(0, 0, 0, 0, 0, 0, '0, "R10");
        check(chan_on == 16'hA5C3, "R10 latch unchanged", 32'(chan_on), 32'hA5C3);

        // R3: config write in special mode, upper bits ignored
        shift_word(16'hFF3C, 1'b1, "R3");
        check(cfg_byte == 8'h3C, "R3 cfg", 32'(cfg_byte), 32'h3C);
        step(0, 0, 0, 1, 0, 0, '0, "R3");
        check(chan_on == 16'hA5C3, "R3 latch unchanged", 32'(chan_on), 32'hA5C3);
        step(0, 0, 1, 1, 0, 0, '0, "R6");

        // R9/R8/R6/R7: fault on channel 0 and 15, capture, read back
        step(0, 0, 1, 1, 0, 0, 16'h8001, "R9");
        step(0, 0, 1, 1, 0, 0, '0, "R9");
        step(0, 0, 0, 1, 0, 0, '0, "R6");
        step(0, 0, 0, 1, 0, 0, '0, "R6");
        step(0, 0, 0, 1, 0, 0, '0, "R6");
        step(0, 0, 0, 1, 0, 0, '0, "R6");
        rd = '0;
        for (int i = 0; i < N; i++) begin
            rd = {rd[N-2:0], ser_out};
            step(1, 0, 1, 1, 0, 0, '0, "R7");
        end
        check(rd == (16'hA5C3 & 16'h7FFE), "R8 status readout", 32'(rd),
              32'(16'hA5C3 & 16'h7FFE));

        // R9: clear pulse restores health
        step(0, 0, 1, 0, 0, 1, '0, "R9");
        step(0, 0, 1, 1, 0, 0, '0, "R9");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, '0, "R9");
        rd = '0;
        for (int i = 0; i < N; i++) begin
            rd = {rd[N-2:0], ser_out};
            step(0, 0, 1, 1, 0, 0, '0, "R9");
        end
        check(rd == 16'hA5C3, "R9 cleared readout", 32'(rd), 32'hA5C3);

        // R11: normal mode, long low enable keeps shifting
        word = 16'h1234;
        for (int i = N - 1; i >= 0; i--) step(word[i], 0, 0, 0, 0, 0, 16'hFFFF, "R11");
        rd = '0;
        for (int i = 0; i < N; i++) begin
            rd = {rd[N-2:0], ser_out};
            step(0, 0, 1, 0, 0, 0, '0, "R11");
        end
        check(rd == 16'h1234, "R11 no capture", 32'(rd), 32'h1234);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 1), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 2) != 0), ($urandom_range(0, 3) == 0) ? 1'b1 : special_mode ^ ($urandom_range(0, 31) == 0),
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 63) == 0),
                 ($urandom_range(0, 15) == 0) ? N'($urandom) : '0, "R1");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule